// File: doc/BRIEF.md
# Configurable Logic Cell

This block is a small logic cell whose function is chosen at run time. Four gate inputs each pass through an optional inverter. The cell then combines them in one of eight ways: three combinational functions, two latches and three flip-flop types. An optional output inverter follows. The result is registered on the system clock. It is offered on a status output and on a pin output that can be switched off. Rising and falling edges of the result can each raise a sticky interrupt flag.

All state lives in the system clock domain. For the flip-flop modes, gate 1 acts as the clock, and its rising edge is found by comparing two consecutive system-clock samples. The set and reset inputs of the sequential modes are level-sensitive. On every system clock they take precedence over the captured data. When both are active, reset wins. The sequential modes drive the cell from their stored state bit. Every mode reaches the status output through one output register.

The asynchronous active-low reset is released on a clock edge through a two-stage synchronizer. The cell is quiet for two edges after reset is released. The third edge after release is the first functional update.

Top module: `clc_core`

## Requirements
- R1: Each bit of `gate_pol` inverts the matching bit of `gate_in` before it enters the cell. Bit 0 is gate 1 and bit 3 is gate 4.
- R2: The combinational modes are as follows, with g1..g4 being the gates after inversion. Mode 3'b000 gives (g1&g2)|(g3&g4). Mode 3'b001 gives (g1|g2)^(g3|g4). Mode 3'b010 gives g1&g2&g3&g4. The result set up by the inputs before edge k appears on `out_status` after edge k.
- R3: Mode 3'b011 is a set/reset latch updated on every system clock. Its set is g1|g2 and its reset is g3|g4. Reset wins when both are active, and with neither active the bit holds.
- R4: Mode 3'b100 is a D flip-flop. A rising g1 seen between two samples loads g2. g3 clears the state and g4 sets it, with clear winning, and both override a clock edge.
- R5: Mode 3'b101 is a D flip-flop with data g2&g4, clocked by a rising g1 and cleared by g3.
- R6: Mode 3'b110 is a J-K flip-flop with J=g2 and K=g4, clocked by a rising g1 and cleared by g3. The J,K pairs act as follows: 10 sets, 01 clears, 11 toggles, 00 holds.
- R7: Mode 3'b111 is a transparent latch. It loads g2 on every clock while g1 is high and holds otherwise. g3 clears it and g4 sets it, with clear winning.
- R8: While `cell_en` is 0, the status and pin outputs are 0 from the next edge on and the stored state bit holds. A pulse on `irq_clr` while disabled also clears the stored state bit.
- R9: With `out_inv` at 1, the cell result is inverted before it is registered. The disabled output stays 0.
- R10: `pin_out` equals the registered output when `pin_en` is 1 and is 0 otherwise.
- R11: With `irq_rise_en` at 1, a 0-to-1 change of `out_status` sets `irq_flag` on the following edge.
- R12: With `irq_fall_en` at 1, a 1-to-0 change of `out_status` sets `irq_flag` on the following edge. The flag stays set until `irq_clr` is pulsed, and a new edge event in the same cycle as the clear keeps it set.
- R13: While reset is asserted, and for two edges after its release, all outputs and all state are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate_in | input | 4 | Gate signals, bit 0 = gate 1 |
| gate_pol | input | 4 | Per-gate inversion |
| cell_en | input | 1 | Cell enable |
| mode | input | 3 | Function select |
| out_inv | input | 1 | Output inversion |
| pin_en | input | 1 | Pin output enable |
| irq_rise_en | input | 1 | Rising-edge interrupt enable |
| irq_fall_en | input | 1 | Falling-edge interrupt enable |
| irq_clr | input | 1 | Interrupt clear strobe (also clears state while disabled) |
| pin_out | output | 1 | Gated pin output |
| out_status | output | 1 | Registered cell output level |
| irq_flag | output | 1 | Sticky interrupt flag |

## Verification
The properties assume that every input is a clean synchronous level sampled at the system clock. They also assume that the control fields are valid whenever the synchronized reset is released. The clock and edge checks rely on gate 1 being held for whole clock periods. The stimulus keeps within these assumptions by changing inputs only on the falling clock edge, so each value is stable across the next rising edge. Gate patterns, including randomized ones, change at most once per cycle, so every flip-flop mode sees its clock edges as whole-cycle level changes.

// File: rtl/clc_pkg.sv
package clc_pkg;
  localparam int GATES     = 4;
  localparam int MODE_W    = 3;
  localparam int RST_STAGE = 2;

  typedef enum logic [MODE_W-1:0] {
    MD_ANDOR   = 3'd0,
    MD_ORXOR   = 3'd1,
    MD_AND4    = 3'd2,
    MD_SRLAT   = 3'd3,
    MD_DFF_SR  = 3'd4,
    MD_DFF2_R  = 3'd5,
    MD_JKFF_R  = 3'd6,
    MD_DLAT_SR = 3'd7
  } clc_mode_e;
endpackage

// File: rtl/clc_rst_sync.sv
module clc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb sh_d = 1'b1;
    end else begin : g_many
      always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/clc_gate_func.sv
module clc_gate_func
  import clc_pkg::*;
(
  input  logic [GATES-1:0] gate_in,
  input  logic [GATES-1:0] gate_pol,
  input  clc_mode_e        mode,
  input  logic             state_q,
  output logic [GATES-1:0] gates,
  output logic             cell_val
);
  // polarity per gate
  genvar gi;
  generate
    for (gi = 0; gi < GATES; gi++) begin : g_pol
      assign gates[gi] = gate_in[gi] ^ gate_pol[gi];
    end
  endgenerate

  always_comb begin
    unique case (mode)
      MD_ANDOR: cell_val = (gates[0] & gates[1]) | (gates[2] & gates[3]);
      MD_ORXOR: cell_val = (gates[0] | gates[1]) ^ (gates[2] | gates[3]);
      MD_AND4:  cell_val = &gates;
      default:  cell_val = state_q;
    endcase
  end
endmodule

// File: rtl/clc_state.sv
module clc_state
  import clc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cell_en,
  input  logic             clr,
  input  clc_mode_e        mode,
  input  logic [GATES-1:0] gates,
  output logic             state_q
);
  logic g1_prev_q;
  logic q_nxt;
  logic q_we;
  logic clk_rise;
  logic s_in, r_in;

  assign clk_rise = gates[0] & ~g1_prev_q;
  assign q_we     = cell_en | clr;

  always_comb begin
    q_nxt = state_q;
    s_in  = 1'b0;
    r_in  = 1'b0;
    if (!cell_en) begin
      if (clr) q_nxt = 1'b0;
    end else begin
      unique case (mode)
        MD_SRLAT: begin
          s_in = gates[0] | gates[1];
          r_in = gates[2] | gates[3];
          if (r_in)      q_nxt = 1'b0;
          else if (s_in) q_nxt = 1'b1;
        end
        MD_DFF_SR: begin
          if (gates[2])      q_nxt = 1'b0;
          else if (gates[3]) q_nxt = 1'b1;
          else if (clk_rise) q_nxt = gates[1];
        end
        MD_DFF2_R: begin
          if (gates[2])      q_nxt = 1'b0;
          else if (clk_rise) q_nxt = gates[1] & gates[3];
        end
        MD_JKFF_R: begin
          if (gates[2]) q_nxt = 1'b0;
          else if (clk_rise) begin
            unique case ({gates[1], gates[3]})
              2'b10:   q_nxt = 1'b1;
              2'b01:   q_nxt = 1'b0;
              2'b11:   q_nxt = ~state_q;
              default: q_nxt = state_q;
            endcase
          end
        end
        MD_DLAT_SR: begin
          if (gates[2])      q_nxt = 1'b0;
          else if (gates[3]) q_nxt = 1'b1;
          else if (gates[0]) q_nxt = gates[1];
        end
        default: q_nxt = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1_prev_q <= 1'b0;
      state_q   <= 1'b0;
    end else begin
      g1_prev_q <= gates[0];
      if (q_we) state_q <= q_nxt;
    end
  end
endmodule

// File: rtl/clc_out_irq.sv
module clc_out_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic cell_en,
  input  logic out_inv,
  input  logic cell_val,
  input  logic pin_en,
  input  logic rise_en,
  input  logic fall_en,
  input  logic clr,
  output logic lc_q,
  output logic pin_out,
  output logic irq_q
);
  logic lc_prev_q;
  logic lc_nxt;
  logic irq_nxt;
  logic rise_evt, fall_evt;

  assign lc_nxt   = cell_en & (cell_val ^ out_inv);
  assign rise_evt = lc_q & ~lc_prev_q;
  assign fall_evt = ~lc_q & lc_prev_q;
  assign irq_nxt  = (irq_q & ~clr) | (rise_en & rise_evt) | (fall_en & fall_evt);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lc_q      <= 1'b0;
      lc_prev_q <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      lc_q      <= lc_nxt;
      lc_prev_q <= lc_q;
      irq_q     <= irq_nxt;
    end
  end

  assign pin_out = pin_en & lc_q;
endmodule

// File: rtl/clc_core.sv
module clc_core
  import clc_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [GATES-1:0] gate_in,
  input  logic [GATES-1:0] gate_pol,
  input  logic             cell_en,
  input  logic [MODE_W-1:0] mode,
  input  logic             out_inv,
  input  logic             pin_en,
  input  logic             irq_rise_en,
  input  logic             irq_fall_en,
  input  logic             irq_clr,
  output logic             pin_out,
  output logic             out_status,
  output logic             irq_flag
);
  logic             rst_sync_n;
  logic [GATES-1:0] gates;
  logic             cell_val;
  logic             state_q;
  clc_mode_e        mode_e;

  assign mode_e = clc_mode_e'(mode);

  clc_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  clc_gate_func u_func (
    .gate_in  (gate_in),
    .gate_pol (gate_pol),
    .mode     (mode_e),
    .state_q  (state_q),
    .gates    (gates),
    .cell_val (cell_val)
  );

  clc_state u_state (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .cell_en (cell_en),
    .clr     (irq_clr),
    .mode    (mode_e),
    .gates   (gates),
    .state_q (state_q)
  );

  clc_out_irq u_out (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cell_en  (cell_en),
    .out_inv  (out_inv),
    .cell_val (cell_val),
    .pin_en   (pin_en),
    .rise_en  (irq_rise_en),
    .fall_en  (irq_fall_en),
    .clr      (irq_clr),
    .lc_q     (out_status),
    .pin_out  (pin_out),
    .irq_q    (irq_flag)
  );
endmodule

// File: rtl/clc_core_chk.sv
module clc_core_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] gate_in,
  input logic [3:0] gate_pol,
  input logic       cell_en,
  input logic [2:0] mode,
  input logic       out_inv,
  input logic       irq_rise_en,
  input logic       irq_fall_en,
  input logic       irq_clr,
  input logic       out_status,
  input logic       irq_flag
);
  // R8
  disabled_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cell_en |=> !out_status);

  // R2
  and4_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && mode == 3'd2 && !out_inv && (gate_in ^ gate_pol) == 4'hF) |=> out_status);

  // R9
  inv_andor_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cell_en && mode == 3'd0 && out_inv && (gate_in ^ gate_pol) == 4'h0) |=> out_status);

  // R11
  rise_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(out_status) && irq_rise_en) |=> irq_flag);

  // R12
  fall_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(out_status) && irq_fall_en) |=> irq_flag);

  // R12
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_flag && !irq_clr) |=> irq_flag);
endmodule

bind clc_core clc_core_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .gate_in     (gate_in),
  .gate_pol    (gate_pol),
  .cell_en     (cell_en),
  .mode        (mode),
  .out_inv     (out_inv),
  .irq_rise_en (irq_rise_en),
  .irq_fall_en (irq_fall_en),
  .irq_clr     (irq_clr),
  .out_status  (out_status),
  .irq_flag    (irq_flag)
);

// File: tb/tb_clc_core.sv
`timescale 1ns/100ps
module tb_clc_core;
  logic       clk;
  logic       rst_n;
  logic [3:0] gate_in, gate_pol;
  logic       cell_en, out_inv, pin_en, irq_rise_en, irq_fall_en, irq_clr;
  logic [2:0] mode;
  logic       pin_out, out_status, irq_flag;

  int    errors = 0;
  int    checks = 0;
  int    cycles = 0;
  string tag = "R13";

  clc_core dut (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in), .gate_pol(gate_pol),
    .cell_en(cell_en), .mode(mode), .out_inv(out_inv), .pin_en(pin_en),
    .irq_rise_en(irq_rise_en), .irq_fall_en(irq_fall_en), .irq_clr(irq_clr),
    .pin_out(pin_out), .out_status(out_status), .irq_flag(irq_flag)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  // reference model state
  int   m_rel = 0;
  logic m_g1p = 0, m_q = 0, m_lc = 0, m_prev = 0, m_irq = 0;

  function automatic logic f_comb(input logic [2:0] md, input logic [3:0] g, input logic q);
    case (md)
      3'd0: return (g[0] & g[1]) | (g[2] & g[3]);
      3'd1: return (g[0] | g[1]) ^ (g[2] | g[3]);
      3'd2: return g[0] & g[1] & g[2] & g[3];
      default: return q;
    endcase
  endfunction

  function automatic logic f_next(input logic [2:0] md, input logic [3:0] g,
                                  input logic q, input logic g1p);
    logic edge1;
    edge1 = g[0] && !g1p;
    case (md)
      3'd3: begin
        if (g[2] || g[3]) return 1'b0;
        if (g[0] || g[1]) return 1'b1;
        return q;
      end
      3'd4: begin
        if (g[2]) return 1'b0;
        if (g[3]) return 1'b1;
        if (edge1) return g[1];
        return q;
      end
      3'd5: begin
        if (g[2]) return 1'b0;
        if (edge1) return g[1] && g[3];
        return q;
      end
      3'd6: begin
        if (g[2]) return 1'b0;
        if (edge1) begin
          if (g[1] && g[3]) return !q;
          if (g[1]) return 1'b1;
          if (g[3]) return 1'b0;
        end
        return q;
      end
      3'd7: begin
        if (g[2]) return 1'b0;
        if (g[3]) return 1'b1;
        if (g[0]) return g[1];
        return q;
      end
      default: return q;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [3:0] g;
    logic n_lc, n_irq, n_q;
    logic e_pin;
    cycles++;
    g = gate_in ^ gate_pol;
    if (!rst_n) m_rel = 0;
    if (!rst_n || m_rel < 2) begin
      if (rst_n) m_rel++;
      m_g1p = 0; m_q = 0; m_lc = 0; m_prev = 0; m_irq = 0;
    end else begin
      n_lc  = cell_en & (f_comb(mode, g, m_q) ^ out_inv);
      n_irq = (m_irq & ~irq_clr) | (irq_rise_en & m_lc & ~m_prev) |
              (irq_fall_en & ~m_lc & m_prev);
      n_q   = cell_en ? f_next(mode, g, m_q, m_g1p) : (irq_clr ? 1'b0 : m_q);
      m_prev = m_lc; m_lc = n_lc; m_irq = n_irq; m_q = n_q; m_g1p = g[0];
    end
    #1;
    e_pin = pin_en & m_lc;
    checks++;
    if (out_status !== m_lc || pin_out !== e_pin || irq_flag !== m_irq) begin
      errors++;
      $display("FAIL %s t=%0t status/pin/irq actual=%b%b%b expected=%b%b%b",
               tag, $time, out_status, pin_out, irq_flag, m_lc, e_pin, m_irq);
    end
    if (cycles > 40000) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic cyc(input logic [3:0] v);
    gate_in = v;
    @(negedge clk);
  endtask

  task automatic pulse_clr();
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
  endtask

  task automatic rand_run(input int n);
    for (int i = 0; i < n; i++) cyc(4'($urandom));
  endtask

  initial begin
    rst_n = 0; gate_in = 0; gate_pol = 0; cell_en = 0; mode = 0;
    out_inv = 0; pin_en = 0; irq_rise_en = 0; irq_fall_en = 0; irq_clr = 0;
    tag = "R13";
    repeat (4) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);

    cell_en = 1; pin_en = 1;
    for (int m = 0; m < 3; m++) begin
      mode = 3'(m);
      tag = "R2"; gate_pol = 4'h0;
      for (int v = 0; v < 16; v++) cyc(4'(v));
      tag = "R1"; gate_pol = 4'b1010;
      for (int v = 0; v < 16; v++) cyc(4'(v));
    end
    gate_pol = 0;

    tag = "R9"; out_inv = 1; mode = 0;
    for (int v = 0; v < 16; v++) cyc(4'(v));
    mode = 3'd4; rand_run(40);
    out_inv = 0;

    tag = "R10"; pin_en = 0; mode = 0;
    for (int v = 0; v < 16; v++) cyc(4'(v));
    pin_en = 1;

    tag = "R3"; mode = 3'd3;
    cyc(4'h1); cyc(4'h0); cyc(4'h4); cyc(4'h0); cyc(4'h2); cyc(4'h0);
    cyc(4'h5); cyc(4'h0); cyc(4'h8); cyc(4'h0); cyc(4'h0);
    rand_run(60);

    tag = "R4"; mode = 3'd4;
    cyc(4'h0); cyc(4'h3); cyc(4'h2); cyc(4'h0); cyc(4'h1); cyc(4'h8);
    cyc(4'hC); cyc(4'h0); cyc(4'h3); cyc(4'h7);
    rand_run(150);

    tag = "R5"; mode = 3'd5;
    cyc(4'h0); cyc(4'hB); cyc(4'h0); cyc(4'h3); cyc(4'h0); cyc(4'hB); cyc(4'h4);
    rand_run(150);

    tag = "R6"; mode = 3'd6;
    cyc(4'h4); cyc(4'h0); cyc(4'h3); cyc(4'h0); cyc(4'hB); cyc(4'h0);
    cyc(4'hB); cyc(4'h0); cyc(4'h9); cyc(4'h0); cyc(4'h1);
    rand_run(150);

    tag = "R7"; mode = 3'd7;
    cyc(4'h3); cyc(4'h1); cyc(4'h0); cyc(4'h2); cyc(4'h8); cyc(4'hC); cyc(4'h0);
    rand_run(150);

    tag = "R8"; mode = 3'd4;
    cyc(4'h8); cyc(4'h0); cyc(4'h0);
    cell_en = 0; rand_run(20);
    cell_en = 1; mode = 3'd4; cyc(4'h1); cyc(4'h1); cyc(4'h1);
    cell_en = 0; cyc(4'h1); pulse_clr();
    cell_en = 1; cyc(4'h1); cyc(4'h1); cyc(4'h1);

    tag = "R11"; mode = 0; irq_rise_en = 1;
    cyc(4'h0); cyc(4'h0); cyc(4'h3); cyc(4'h3); cyc(4'h0); cyc(4'h0);
    pulse_clr(); cyc(4'h0); cyc(4'h3); cyc(4'h3); cyc(4'h3); irq_clr = 1; cyc(4'h3);
    irq_clr = 0; irq_rise_en = 0;

    tag = "R12"; irq_fall_en = 1;
    pulse_clr(); cyc(4'h3); cyc(4'h0); cyc(4'h0); cyc(4'h0);
    cyc(4'h3); cyc(4'h3); irq_clr = 1; cyc(4'h0); cyc(4'h0); irq_clr = 0;
    cyc(4'h0); cyc(4'h3); irq_fall_en = 0; pulse_clr(); cyc(4'h0); cyc(4'h0);

    tag = "R11";
    for (int i = 0; i < 500; i++) begin
      {cell_en, out_inv, pin_en, irq_rise_en, irq_fall_en} = 5'($urandom);
      cell_en = cell_en | ($urandom_range(3) != 0);
      mode = 3'($urandom); gate_pol = 4'($urandom);
      irq_clr = ($urandom_range(7) == 0);
      cyc(4'($urandom));
    end
    irq_clr = 0;

    tag = "R13"; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule